// File: doc/BRIEF.md
# Ethernet Pause Flow Controller

This block sits beside a MAC receive buffer. It watches how many kilobytes of that buffer are still free and decides when the transmitter must send an IEEE 802.3x PAUSE control frame. When free space drops below a high-water mark, it asks for an XOFF frame with pause time FFFFh. After that XOFF frame has actually gone out and free space has climbed back above a low-water mark, it asks for an XON frame with pause time 0000h. The two marks form a hysteresis loop, so each crossing produces exactly one frame.

Software can also force either frame with self-clearing control bits. In half duplex the block can instead jam arriving packets while the buffer is too full. This jam mode applies either to every packet or only to packets whose destination address matched. The block also keeps a clear-on-read flag for received PAUSE frames, and a control bit that holds off normal transmission.

The pause request leaves the block as a valid/ready stream of one 16-bit word, the pause time. Once `pause_valid` is high, `pause_valid` and `pause_time` stay unchanged until a cycle in which `pause_ready` is also high. That cycle is the handshake and means the frame has been sent. `pause_valid` is low in the cycle after a handshake, so there is at least one idle cycle between requests.

Top module: `pause_flow_ctrl`

## Requirements
- R1: After reset, the threshold register (address 0) reads 83h, the control register (address 1) reads 00h with `rx_pause_active` low, and `pause_valid`, `pause_time`, `jam_req` and `tx_hold` are all 0.
- R2: The threshold register holds the high mark in bits [3:0] and the low mark in bits [7:4], both in kilobytes. While the enable bit (control bit 0) is set and `free_kb` is below the high mark, an XOFF request (`pause_time` = FFFFh) is raised within two cycles.
- R3: A high mark of 0 raises the XOFF request only when `free_kb` is 0.
- R4: An XON request (`pause_time` = 0000h) is raised only when both hold: an XOFF handshake has completed since the last XON, and `free_kb` exceeds the low mark.
- R5: While control bit 0 is clear, the thresholds raise no request.
- R6: Control bit 1 forces an XOFF request and control bit 2 forces an XON request. Each bit clears itself on the handshake of a frame with its pause time, unless the control register is written in that same cycle; the write takes precedence.
- R7: When an XOFF and an XON request are both pending, the XOFF request is presented first.
- R8: One high-water crossing produces one XOFF frame. No further XOFF follows while free space stays low.
- R9: With control bit 3 set and `half_duplex` high, `jam_req` pulses in the cycle after `rx_pkt_start` if occupancy (BUF_KB − `free_kb`) exceeds BP_MARK_KB.
- R10: With control bit 4 set, the jam additionally requires `rx_da_match`. No jam is ever raised while `half_duplex` is low.
- R11: Control bit 6 latches on `rx_pause_frame` and clears on a read of address 1. A new frame in the same cycle as the read takes precedence. Control bit 7 shows `rx_pause_active` directly.
- R12: `tx_hold` follows control bit 5.
- R13: While `pause_valid` is high and `pause_ready` is low, `pause_valid` and `pause_time` hold steady. `pause_valid` is low in the cycle after a handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (clears the latched pause flag on address 1) |
| reg_addr | input | 1 | Register select: 0 = thresholds, 1 = control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| free_kb | input | FREE_W | Free receive buffer space in kilobytes |
| pause_valid | output | 1 | Pause frame request valid |
| pause_ready | input | 1 | Transmitter accepts / has sent the frame |
| pause_time | output | 16 | Pause time of the requested frame |
| half_duplex | input | 1 | Link is half duplex |
| rx_pkt_start | input | 1 | Pulse: a packet starts arriving |
| rx_da_match | input | 1 | Destination address of the arriving packet matched |
| jam_req | output | 1 | Pulse: jam the arriving packet |
| rx_pause_frame | input | 1 | Pulse: a PAUSE frame was received |
| rx_pause_active | input | 1 | Received pause is currently in effect |
| tx_hold | output | 1 | Hold off normal transmission |

## Verification
The bench builds the block with FREE_W = 5, BUF_KB = 16 and BP_MARK_KB = 12. A 5-bit `free_kb` reaches values above every 4-bit mark and even above the buffer size, so both sides of each threshold and the zero-high-mark case can be driven. A 16 KB buffer with a 12 KB jam mark puts the occupancy limit within a few steps of free space, so jam and no-jam cases sit next to each other. Stalling `pause_ready` for several cycles exposes the hold rule, and forcing both frames at once exposes the XOFF-first ordering.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int TH_W  = 4;
  localparam int REG_W = 2 * TH_W;
  localparam int PT_W  = 16;

  localparam logic [PT_W-1:0] PT_XOFF = 16'hFFFF;
  localparam logic [PT_W-1:0] PT_XON  = 16'h0000;

  localparam logic ADDR_THR  = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  // control register bit positions
  localparam int CB_THR_EN = 0;
  localparam int CB_F_XOFF = 1;
  localparam int CB_F_XON  = 2;
  localparam int CB_BP_ANY = 3;
  localparam int CB_BP_DA  = 4;
  localparam int CB_HOLD   = 5;
  localparam int CB_SEEN   = 6;
  localparam int CB_LIVE   = 7;

  typedef enum logic [1:0] {
    W_IDLE      = 2'd0,
    W_XOFF_PEND = 2'd1,
    W_XOFF_SENT = 2'd2,
    W_XON_PEND  = 2'd3
  } water_state_e;

  typedef struct packed {
    logic [TH_W-1:0] lo_mark;
    logic [TH_W-1:0] hi_mark;
    logic            thr_en;
    logic            force_xoff;
    logic            force_xon;
    logic            bp_any;
    logic            bp_da;
    logic            hold;
  } pfc_cfg_t;
endpackage

// File: rtl/pfc_regs.sv
module pfc_regs
  import pfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             rx_pause_frame,
  input  logic             rx_pause_active,
  input  logic             done_xoff,
  input  logic             done_xon,
  output pfc_cfg_t         cfg
);
  logic seen_q;
  logic wr_thr, wr_ctrl;

  assign wr_thr  = wr_en && (addr == ADDR_THR);
  assign wr_ctrl = wr_en && (addr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.hi_mark    <= TH_W'(3);
      cfg.lo_mark    <= TH_W'(8);
      cfg.thr_en     <= 1'b0;
      cfg.force_xoff <= 1'b0;
      cfg.force_xon  <= 1'b0;
      cfg.bp_any     <= 1'b0;
      cfg.bp_da      <= 1'b0;
      cfg.hold       <= 1'b0;
    end else begin
      if (wr_thr) begin
        cfg.hi_mark <= wdata[TH_W-1:0];
        cfg.lo_mark <= wdata[REG_W-1:TH_W];
      end
      if (wr_ctrl) begin
        cfg.thr_en     <= wdata[CB_THR_EN];
        cfg.force_xoff <= wdata[CB_F_XOFF];
        cfg.force_xon  <= wdata[CB_F_XON];
        cfg.bp_any     <= wdata[CB_BP_ANY];
        cfg.bp_da      <= wdata[CB_BP_DA];
        cfg.hold       <= wdata[CB_HOLD];
      end else begin
        if (done_xoff) cfg.force_xoff <= 1'b0;
        if (done_xon)  cfg.force_xon  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                    seen_q <= 1'b0;
    else if (rx_pause_frame)                       seen_q <= 1'b1;
    else if (rd_en && (addr == ADDR_CTRL))         seen_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_THR) begin
      rdata = {cfg.lo_mark, cfg.hi_mark};
    end else begin
      rdata[CB_THR_EN] = cfg.thr_en;
      rdata[CB_F_XOFF] = cfg.force_xoff;
      rdata[CB_F_XON]  = cfg.force_xon;
      rdata[CB_BP_ANY] = cfg.bp_any;
      rdata[CB_BP_DA]  = cfg.bp_da;
      rdata[CB_HOLD]   = cfg.hold;
      rdata[CB_SEEN]   = seen_q;
      rdata[CB_LIVE]   = rx_pause_active;
    end
  end
endmodule

// File: rtl/pfc_water.sv
module pfc_water
  import pfc_pkg::*;
#(
  parameter int FREE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_en,
  input  logic [TH_W-1:0]   hi_mark,
  input  logic [TH_W-1:0]   lo_mark,
  input  logic [FREE_W-1:0] free_kb,
  input  logic              done_xoff,
  input  logic              done_xon,
  output logic              want_xoff,
  output logic              want_xon
);
  localparam int CMP_W = (FREE_W > TH_W) ? FREE_W : TH_W;

  water_state_e state_q, state_d;
  logic [CMP_W-1:0] free_x, hi_x, lo_x;
  logic hi_hit, lo_hit;

  assign free_x = CMP_W'(free_kb);
  assign hi_x   = CMP_W'(hi_mark);
  assign lo_x   = CMP_W'(lo_mark);

  // a zero high mark stands for a completely full buffer
  assign hi_hit = (hi_mark == '0) ? (free_x == '0) : (free_x < hi_x);
  assign lo_hit = free_x > lo_x;

  always_comb begin
    state_d = state_q;
    if (!thr_en) begin
      state_d = W_IDLE;
    end else begin
      unique case (state_q)
        W_IDLE:      if (hi_hit)    state_d = W_XOFF_PEND;
        W_XOFF_PEND: if (done_xoff) state_d = W_XOFF_SENT;
        W_XOFF_SENT: if (lo_hit)    state_d = W_XON_PEND;
        W_XON_PEND:  if (done_xon)  state_d = W_IDLE;
        default:                    state_d = W_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= W_IDLE;
    else        state_q <= state_d;
  end

  assign want_xoff = (state_q == W_XOFF_PEND);
  assign want_xon  = (state_q == W_XON_PEND);
endmodule

// File: rtl/pfc_arb.sv
module pfc_arb
  import pfc_pkg::*;
#(
  parameter int N_SRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_SRC-1:0] xoff_src,
  input  logic [N_SRC-1:0] xon_src,
  output logic            pause_valid,
  output logic [PT_W-1:0] pause_time,
  input  logic            pause_ready,
  output logic            done_xoff,
  output logic            done_xon
);
  logic any_xoff, any_xon, hs;

  assign any_xoff = |xoff_src;
  assign any_xon  = |xon_src;
  assign hs       = pause_valid && pause_ready;

  assign done_xoff = hs && (pause_time == PT_XOFF);
  assign done_xon  = hs && (pause_time == PT_XON);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause_valid <= 1'b0;
      pause_time  <= PT_XON;
    end else if (hs) begin
      pause_valid <= 1'b0;
    end else if (!pause_valid && (any_xoff || any_xon)) begin
      pause_valid <= 1'b1;
      pause_time  <= any_xoff ? PT_XOFF : PT_XON;
    end
  end
endmodule

// File: rtl/pfc_jam.sv
module pfc_jam #(
  parameter int FREE_W     = 5,
  parameter int BUF_KB     = 16,
  parameter int BP_MARK_KB = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bp_any,
  input  logic              bp_da,
  input  logic              half_duplex,
  input  logic              rx_pkt_start,
  input  logic              rx_da_match,
  input  logic [FREE_W-1:0] free_kb,
  output logic              jam_req
);
  localparam int OCC_W = FREE_W + 2;
  localparam logic [OCC_W-1:0] BUF_X  = OCC_W'(BUF_KB);
  localparam logic [OCC_W-1:0] MARK_X = OCC_W'(BP_MARK_KB);

  logic [OCC_W-1:0] free_x, occ;
  logic over, hit;

  assign free_x = OCC_W'(free_kb);
  assign occ    = (free_x >= BUF_X) ? '0 : (BUF_X - free_x);
  assign over   = occ > MARK_X;
  assign hit    = half_duplex && rx_pkt_start && over &&
                  (bp_any || (bp_da && rx_da_match));

  always_ff @(posedge clk) begin
    if (!rst_n) jam_req <= 1'b0;
    else        jam_req <= hit;
  end
endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
  import pfc_pkg::*;
#(
  parameter int FREE_W     = 5,
  parameter int BUF_KB     = 16,
  parameter int BP_MARK_KB = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic              reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [FREE_W-1:0] free_kb,
  output logic              pause_valid,
  input  logic              pause_ready,
  output logic [15:0]       pause_time,
  input  logic              half_duplex,
  input  logic              rx_pkt_start,
  input  logic              rx_da_match,
  output logic              jam_req,
  input  logic              rx_pause_frame,
  input  logic              rx_pause_active,
  output logic              tx_hold
);
  localparam int N_SRC = 2;

  pfc_cfg_t cfg;
  logic done_xoff, done_xon;
  logic want_xoff, want_xon;
  logic [N_SRC-1:0] xoff_src, xon_src;

  pfc_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .rx_pause_frame(rx_pause_frame), .rx_pause_active(rx_pause_active),
    .done_xoff(done_xoff), .done_xon(done_xon),
    .cfg(cfg)
  );

  pfc_water #(.FREE_W(FREE_W)) u_water (
    .clk(clk), .rst_n(rst_n),
    .thr_en(cfg.thr_en), .hi_mark(cfg.hi_mark), .lo_mark(cfg.lo_mark),
    .free_kb(free_kb),
    .done_xoff(done_xoff), .done_xon(done_xon),
    .want_xoff(want_xoff), .want_xon(want_xon)
  );

  assign xoff_src = {cfg.force_xoff, want_xoff};
  assign xon_src  = {cfg.force_xon,  want_xon};

  pfc_arb #(.N_SRC(N_SRC)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .xoff_src(xoff_src), .xon_src(xon_src),
    .pause_valid(pause_valid), .pause_time(pause_time),
    .pause_ready(pause_ready),
    .done_xoff(done_xoff), .done_xon(done_xon)
  );

  pfc_jam #(.FREE_W(FREE_W), .BUF_KB(BUF_KB), .BP_MARK_KB(BP_MARK_KB)) u_jam (
    .clk(clk), .rst_n(rst_n),
    .bp_any(cfg.bp_any), .bp_da(cfg.bp_da),
    .half_duplex(half_duplex), .rx_pkt_start(rx_pkt_start),
    .rx_da_match(rx_da_match), .free_kb(free_kb),
    .jam_req(jam_req)
  );

  assign tx_hold = cfg.hold;
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        pause_valid,
  input logic        pause_ready,
  input logic [15:0] pause_time,
  input logic        jam_req,
  input logic        half_duplex,
  input logic        rx_pause_frame,
  input logic        reg_addr,
  input logic [7:0]  reg_rdata
);
  assert_hold_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_valid && !pause_ready) |=> (pause_valid && $stable(pause_time)));

  assert_gap_after_hs_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_valid && pause_ready) |=> !pause_valid);

  assert_time_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pause_valid |-> (pause_time == 16'hFFFF || pause_time == 16'h0000));

  assert_jam_half_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    jam_req |-> $past(half_duplex));

  assert_seen_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pause_frame |=> (reg_addr != 1'b1 || reg_rdata[6]));
endmodule

bind pause_flow_ctrl pfc_checker u_pfc_checker (
  .clk(clk), .rst_n(rst_n),
  .pause_valid(pause_valid), .pause_ready(pause_ready), .pause_time(pause_time),
  .jam_req(jam_req), .half_duplex(half_duplex),
  .rx_pause_frame(rx_pause_frame), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/test_pause_flow_ctrl.sv
`timescale 1ns/1ps
module test_pause_flow_ctrl;
  localparam int FREE_W = 5;
  localparam int BUF_KB = 16;
  localparam int BP_MARK_KB = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 0, reg_rd_en = 0, reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [FREE_W-1:0] free_kb = 20;
  logic pause_valid, pause_ready = 0;
  logic [15:0] pause_time;
  logic half_duplex = 0, rx_pkt_start = 0, rx_da_match = 0, jam_req;
  logic rx_pause_frame = 0, rx_pause_active = 0, tx_hold;

  int tests = 0, fails = 0;
  bit started = 0;

  always #4 clk = ~clk;

  pause_flow_ctrl #(.FREE_W(FREE_W), .BUF_KB(BUF_KB), .BP_MARK_KB(BP_MARK_KB)) i_pause_flow_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .free_kb(free_kb),
    .pause_valid(pause_valid), .pause_ready(pause_ready), .pause_time(pause_time),
    .half_duplex(half_duplex), .rx_pkt_start(rx_pkt_start), .rx_da_match(rx_da_match),
    .jam_req(jam_req),
    .rx_pause_frame(rx_pause_frame), .rx_pause_active(rx_pause_active),
    .tx_hold(tx_hold)
  );

  // ---------------- behavioural reference model ----------------
  int m_hi, m_lo, m_ws;
  bit m_thr, m_fx, m_fn, m_bpa, m_bpm, m_hold, m_seen, m_valid, m_jam;
  int m_time;

  function automatic int model_rdata(bit a);
    if (a == 0) return (m_lo << 4) | m_hi;
    return m_thr | (m_fx << 1) | (m_fn << 2) | (m_bpa << 3) | (m_bpm << 4) |
           (m_hold << 5) | (m_seen << 6) | (int'(rx_pause_active) << 7);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = 3; m_lo = 8; m_ws = 0;
      m_thr = 0; m_fx = 0; m_fn = 0; m_bpa = 0; m_bpm = 0; m_hold = 0; m_seen = 0;
      m_valid = 0; m_time = 0; m_jam = 0;
    end else begin
      bit hs, d_off, d_on, hi_hit, w_off, w_on;
      int n_ws, fr, occ;
      fr = int'(free_kb);
      hs = m_valid && pause_ready;
      d_off = hs && (m_time == 16'hFFFF);
      d_on  = hs && (m_time == 0);
      hi_hit = (m_hi == 0) ? (fr == 0) : (fr < m_hi);
      n_ws = m_ws;
      if (!m_thr) n_ws = 0;
      else if (m_ws == 0 && hi_hit) n_ws = 1;
      else if (m_ws == 1 && d_off) n_ws = 2;
      else if (m_ws == 2 && fr > m_lo) n_ws = 3;
      else if (m_ws == 3 && d_on) n_ws = 0;
      w_off = m_fx || (m_ws == 1);
      w_on  = m_fn || (m_ws == 3);
      if (hs) m_valid = 0;
      else if (!m_valid && (w_off || w_on)) begin
        m_valid = 1;
        m_time = w_off ? 16'hFFFF : 0;
      end
      occ = (fr >= BUF_KB) ? 0 : BUF_KB - fr;
      m_jam = half_duplex && rx_pkt_start && (occ > BP_MARK_KB) &&
              (m_bpa || (m_bpm && rx_da_match));
      if (rx_pause_frame) m_seen = 1;
      else if (reg_rd_en && reg_addr) m_seen = 0;
      if (reg_wr_en && !reg_addr) begin
        m_hi = reg_wdata[3:0]; m_lo = reg_wdata[7:4];
      end
      if (reg_wr_en && reg_addr) begin
        m_thr = reg_wdata[0]; m_fx = reg_wdata[1]; m_fn = reg_wdata[2];
        m_bpa = reg_wdata[3]; m_bpm = reg_wdata[4]; m_hold = reg_wdata[5];
      end else begin
        if (d_off) m_fx = 0;
        if (d_on)  m_fn = 0;
      end
      m_ws = n_ws;
    end
    started = 1;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model every clock, at the falling edge
  always @(negedge clk) begin
    if (started) begin
      chk(pause_valid == m_valid, "R2/R4 pause_valid", pause_valid, m_valid);
      if (m_valid) chk(pause_time == m_time[15:0], "R7 pause_time", pause_time, m_time);
      chk(jam_req == m_jam, "R9/R10 jam_req", jam_req, m_jam);
      chk(tx_hold == m_hold, "R12 tx_hold", tx_hold, m_hold);
      chk(reg_rdata == model_rdata(reg_addr), "R6/R11 reg_rdata", reg_rdata, model_rdata(reg_addr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(bit a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1; cyc(1); reg_wr_en = 0;
  endtask

  task automatic rd(bit a);
    reg_addr = a; reg_rd_en = 1; cyc(1); reg_rd_en = 0;
  endtask

  task automatic handshake();
    pause_ready = 1; cyc(1); pause_ready = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    // R1 reset state
    reg_addr = 0; #1;
    chk(reg_rdata == 8'h83, "R1 threshold reset", reg_rdata, 8'h83);
    chk(!pause_valid && !jam_req && !tx_hold, "R1 outputs reset", {pause_valid, jam_req, tx_hold}, 0);
    rst_n = 1; cyc(2);
    reg_addr = 1; #1;
    chk(reg_rdata == 8'h00, "R1 control reset", reg_rdata, 0);

    // R2 / R13 / R8 / R4
    wr(1, 8'h01);
    free_kb = 2; cyc(6);
    chk(pause_valid && pause_time == 16'hFFFF, "R2 xoff raised", pause_time, 16'hFFFF);
    handshake();
    chk(!pause_valid, "R13 gap after handshake", pause_valid, 0);
    cyc(8);
    chk(!pause_valid, "R8 single xoff", pause_valid, 0);
    free_kb = 5; cyc(5);
    chk(!pause_valid, "R4 no xon inside band", pause_valid, 0);
    free_kb = 9; cyc(3);
    chk(pause_valid && pause_time == 16'h0000, "R4 xon raised", pause_time, 0);
    cyc(3);
    handshake(); cyc(4);
    chk(!pause_valid, "R4 xon once", pause_valid, 0);

    // R3 zero high mark
    wr(0, 8'h80);
    free_kb = 1; cyc(5);
    chk(!pause_valid, "R3 no xoff at 1KB", pause_valid, 0);
    free_kb = 0; cyc(3);
    chk(pause_valid && pause_time == 16'hFFFF, "R3 xoff at full", pause_time, 16'hFFFF);
    handshake(); free_kb = 20; cyc(3);
    handshake(); cyc(3);

    // R5 thresholds disabled
    wr(1, 8'h00); wr(0, 8'h83);
    free_kb = 0; cyc(6);
    chk(!pause_valid, "R5 disabled", pause_valid, 0);

    // R6 / R7 forced frames
    wr(1, 8'h06); cyc(2);
    chk(pause_valid && pause_time == 16'hFFFF, "R7 xoff first", pause_time, 16'hFFFF);
    handshake(); cyc(3);
    chk(pause_valid && pause_time == 16'h0000, "R6 forced xon", pause_time, 0);
    handshake(); cyc(2);
    reg_addr = 1; #1;
    chk(reg_rdata[2:1] == 2'b00, "R6 force bits cleared", reg_rdata[2:1], 0);

    // R9 / R10 back-pressure
    free_kb = 2; half_duplex = 1;
    wr(1, 8'h08);
    rx_pkt_start = 1; cyc(1); rx_pkt_start = 0;
    chk(jam_req, "R9 jam any", jam_req, 1);
    cyc(1);
    chk(!jam_req, "R9 jam is a pulse", jam_req, 0);
    wr(1, 8'h10);
    rx_pkt_start = 1; rx_da_match = 0; cyc(1); rx_pkt_start = 0;
    chk(!jam_req, "R10 no match no jam", jam_req, 0);
    rx_pkt_start = 1; rx_da_match = 1; cyc(1); rx_pkt_start = 0;
    chk(jam_req, "R10 match jam", jam_req, 1);
    half_duplex = 0;
    rx_pkt_start = 1; cyc(1); rx_pkt_start = 0;
    chk(!jam_req, "R10 full duplex no jam", jam_req, 0);
    half_duplex = 1; free_kb = 10;
    rx_pkt_start = 1; cyc(1); rx_pkt_start = 0; rx_da_match = 0;
    chk(!jam_req, "R9 below mark no jam", jam_req, 0);

    // R11 received pause status
    reg_addr = 1;
    rx_pause_frame = 1; cyc(1); rx_pause_frame = 0;
    chk(reg_rdata[6], "R11 latched", reg_rdata[6], 1);
    rd(1);
    chk(!reg_rdata[6], "R11 cleared by read", reg_rdata[6], 0);
    rx_pause_active = 1; #1;
    chk(reg_rdata[7], "R11 live bit", reg_rdata[7], 1);
    rx_pause_active = 0;

    // R12 transmit hold
    wr(1, 8'h20); #1;
    chk(tx_hold, "R12 tx_hold set", tx_hold, 1);
    wr(1, 8'h00); #1;
    chk(!tx_hold, "R12 tx_hold clear", tx_hold, 0);

    cyc(4);
    finish_run();
  end
endmodule